// File: doc/BRIEF.md
# SDIO Read-Wait Data-Line Controller

This block is the read-wait section of an SD host's receive data path and runs on the card clock. Read-wait is available only when SDIO operation and D2 signalling are selected. With the data path enabled for card-to-host transfers and a read-wait request raised, the block leaves idle at once and does not wait for a first block. It pulls D2 low after a fixed delay. While the line is held low it watches D1 and reports a low level as an SDIO interrupt.

A stop request ends the interval. D2 stays low for two more card-clock cycles, then goes high for exactly one cycle. After that the block releases the line and waits for data. If a read-wait request arrives while a block is being received, it is held off until that block's CRC has been received. Clearing the data-path enable returns the block to idle and releases D2 at once. The D2 output registers update on the falling edge of the card clock, so the line changes half a cycle after the state changes.

Top module: `sdio_rw_ctrl`

## Requirements
- R1: Read-wait is entered only when all of these hold in the same cycle: the data path is enabled, direction is card-to-host (`dir_rx_i`=1), the method select is D2 signalling (`rw_method_i`=0), start is 1 and stop is 0. If any one of them is missing, the block stays idle.
- R2: From idle, a qualified request moves the state to readwait_delay on the next clock edge. No data block needs to arrive first.
- R3: D2 is driven low (`d2_oe_o`=1, `d2_o`=0) from the third cycle after read-wait entry. The first two cycles spent in readwait_delay leave it released.
- R4: A stop request in readwait_hold starts two stop_delay cycles with D2 still low. These are followed by exactly one stop_pulse cycle with D2 driven high.
- R5: After the high pulse, the state becomes wait_data and `d2_oe_o` returns to 0.
- R6: A request made while a block is being received (receiving state) has no effect until `crc_done_i`. On that cycle the block goes straight to readwait_delay if the request still qualifies.
- R7: While stop remains 1, no new read-wait starts. Once stop is cleared and start is 1, wait_data moves to readwait_delay.
- R8: `sdio_irq_o` is 1 exactly when the state is readwait_delay, readwait_hold or stop_delay and `d1_i` is 0.
- R9: With `sdio_en_i`=0, the block never leaves idle because of a read-wait request, and D2 stays released.
- R10: `dpath_en_i`=0 forces `d2_oe_o` to 0 in the same cycle and idle on the next edge.
- R11: `state_o` encoding: idle=0, readwait_delay=1, readwait_hold=2, stop_delay=3, stop_pulse=4, wait_data=5, receiving=6. Reset gives idle.
- R12: `d2_oe_o` and `d2_o` change only on the falling edge of `clk_i`, or immediately through the data-path enable gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dpath_en_i | input | 1 | Data path enable |
| dir_rx_i | input | 1 | 1 = card-to-host transfer |
| sdio_en_i | input | 1 | SDIO-specific operation enable |
| rw_start_i | input | 1 | Read-wait start request |
| rw_stop_i | input | 1 | Read-wait stop request |
| rw_method_i | input | 1 | 0 = D2 signalling, 1 = other method |
| blk_active_i | input | 1 | A data block is being received |
| crc_done_i | input | 1 | CRC of the current block received |
| d1_i | input | 1 | Sampled D1 line |
| d2_oe_o | output | 1 | D2 output enable |
| d2_o | output | 1 | D2 output value |
| sdio_irq_o | output | 1 | SDIO interrupt seen on D1 during read-wait |
| state_o | output | 3 | Encoded controller state |

## Verification
A wrong state shows up on `state_o` on the next clock edge. Within half a cycle it also appears on `d2_oe_o` and `d2_o`, at the next falling edge. An off-by-one delay counter lengthens or shortens the low interval or the high pulse by one cycle, which is visible the first time read-wait runs. A lost postponement shows as D2 being pulled low during a block instead of after its CRC. A cycle-level reference model in the bench compares every output on every clock. It also checks that the output-enable does not move before the falling edge.

// File: rtl/sdio_rw_pkg.sv
package sdio_rw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RW_DLY    = 3'd1,
    ST_RW_HOLD   = 3'd2,
    ST_STOP_DLY  = 3'd3,
    ST_STOP_PULS = 3'd4,
    ST_WAIT_DATA = 3'd5,
    ST_RECV      = 3'd6
  } rw_state_e;
endpackage

// File: rtl/sdio_rw_qual.sv
module sdio_rw_qual (
  input  logic dpath_en_i,
  input  logic dir_rx_i,
  input  logic sdio_en_i,
  input  logic rw_start_i,
  input  logic rw_stop_i,
  input  logic rw_method_i,
  output logic go_o
);
  // stop must be low so a pending stop blocks re-entry
  assign go_o = dpath_en_i & dir_rx_i & sdio_en_i & ~rw_method_i
              & rw_start_i & ~rw_stop_i;
endmodule

// File: rtl/sdio_rw_fsm.sv
module sdio_rw_fsm
  import sdio_rw_pkg::*;
#(
  parameter int RW_DLY_CYC   = 2,
  parameter int STOP_DLY_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dpath_en_i,
  input  logic      sdio_en_i,
  input  logic      go_i,
  input  logic      stop_i,
  input  logic      blk_i,
  input  logic      crc_i,
  output rw_state_e state_o
);
  localparam int MAX_DLY = (RW_DLY_CYC > STOP_DLY_CYC) ? RW_DLY_CYC : STOP_DLY_CYC;
  localparam int CW      = $clog2(MAX_DLY + 1);
  localparam logic [CW-1:0] RW_LAST   = CW'(RW_DLY_CYC - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_DLY_CYC - 1);

  rw_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    if (!dpath_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (blk_i) state_d = ST_RECV;
                      else if (go_i) state_d = ST_RW_DLY;
        ST_RW_DLY:    if (cnt_q == RW_LAST) state_d = ST_RW_HOLD;
        ST_RW_HOLD:   if (stop_i) state_d = ST_STOP_DLY;
        ST_STOP_DLY:  if (cnt_q == STOP_LAST) state_d = ST_STOP_PULS;
        ST_STOP_PULS: state_d = ST_WAIT_DATA;
        ST_WAIT_DATA: if (blk_i) state_d = ST_RECV;
                      else if (go_i) state_d = ST_RW_DLY;
        ST_RECV:      if (crc_i) state_d = go_i ? ST_RW_DLY : ST_WAIT_DATA;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == state_q && (state_q == ST_RW_DLY || state_q == ST_STOP_DLY))
        cnt_q <= cnt_q + 1'b1;
      else
        cnt_q <= '0;
    end
  end

  assign state_o = state_q;

  // R4
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP_PULS |=> state_q != ST_STOP_PULS);
  // R4
  stop_takes_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RW_HOLD && stop_i && dpath_en_i) |=> state_q == ST_STOP_DLY);
  // R6
  recv_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && !crc_i && dpath_en_i) |=> state_q == ST_RECV);
  // R9
  no_sdio_no_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !sdio_en_i) |=> state_q != ST_RW_DLY);
  // R10
  dpath_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dpath_en_i |=> state_q == ST_IDLE);
  // R5
  pulse_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP_PULS && dpath_en_i) |=> state_q == ST_WAIT_DATA);
endmodule

// File: rtl/sdio_rw_line.sv
module sdio_rw_line
  import sdio_rw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dpath_en_i,
  input  rw_state_e state_i,
  input  logic      d1_i,
  output logic      d2_oe_o,
  output logic      d2_o,
  output logic      sdio_irq_o
);
  logic oe_q, val_q;

  // D2 launched on the falling edge of the card clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
    end else begin
      oe_q  <= (state_i == ST_RW_HOLD) || (state_i == ST_STOP_DLY) || (state_i == ST_STOP_PULS);
      val_q <= (state_i == ST_STOP_PULS);
    end
  end

  assign d2_oe_o    = oe_q & dpath_en_i;
  assign d2_o       = val_q;
  assign sdio_irq_o = ~d1_i & ((state_i == ST_RW_DLY) || (state_i == ST_RW_HOLD)
                            || (state_i == ST_STOP_DLY));

  // R10
  oe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dpath_en_i |-> !d2_oe_o);
endmodule

// File: rtl/sdio_rw_ctrl.sv
module sdio_rw_ctrl
  import sdio_rw_pkg::*;
#(
  parameter int RW_DLY_CYC   = 2,
  parameter int STOP_DLY_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dpath_en_i,
  input  logic       dir_rx_i,
  input  logic       sdio_en_i,
  input  logic       rw_start_i,
  input  logic       rw_stop_i,
  input  logic       rw_method_i,
  input  logic       blk_active_i,
  input  logic       crc_done_i,
  input  logic       d1_i,
  output logic       d2_oe_o,
  output logic       d2_o,
  output logic       sdio_irq_o,
  output logic [2:0] state_o
);
  logic      go;
  rw_state_e state;

  sdio_rw_qual i_qual (
    .dpath_en_i (dpath_en_i),
    .dir_rx_i   (dir_rx_i),
    .sdio_en_i  (sdio_en_i),
    .rw_start_i (rw_start_i),
    .rw_stop_i  (rw_stop_i),
    .rw_method_i(rw_method_i),
    .go_o       (go)
  );

  sdio_rw_fsm #(
    .RW_DLY_CYC  (RW_DLY_CYC),
    .STOP_DLY_CYC(STOP_DLY_CYC)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dpath_en_i(dpath_en_i),
    .sdio_en_i (sdio_en_i),
    .go_i      (go),
    .stop_i    (rw_stop_i),
    .blk_i     (blk_active_i),
    .crc_i     (crc_done_i),
    .state_o   (state)
  );

  sdio_rw_line i_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dpath_en_i(dpath_en_i),
    .state_i   (state),
    .d1_i      (d1_i),
    .d2_oe_o   (d2_oe_o),
    .d2_o      (d2_o),
    .sdio_irq_o(sdio_irq_o)
  );

  assign state_o = state;

  // R7
  stop_blocks_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT_DATA && rw_stop_i) |=> state != ST_RW_DLY);
endmodule

// File: tb/test_sdio_rw_ctrl.sv
`timescale 1ns/1ps
module test_sdio_rw_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dp = 0, dir = 0, sd = 0, start = 0, stop = 0, meth = 0, blk = 0, crc = 0, d1 = 1;
  logic d2_oe, d2, irq;
  logic [2:0] st;
  int total = 0, bad = 0;
  bit done = 0;
  int ms = 0, pms = 0, tmr = 0;

  always #10 clk = ~clk;

  sdio_rw_ctrl i_sdio_rw_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dpath_en_i(dp), .dir_rx_i(dir), .sdio_en_i(sd),
    .rw_start_i(start), .rw_stop_i(stop), .rw_method_i(meth), .blk_active_i(blk),
    .crc_done_i(crc), .d1_i(d1), .d2_oe_o(d2_oe), .d2_o(d2), .sdio_irq_o(irq),
    .state_o(st));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // behavioural reference: state number plus countdown timer
  always @(posedge clk) begin
    bit go;
    pms = ms;
    go = dp && sd && dir && !meth && start && !stop;
    if (!rst_n || !dp) begin ms = 0; tmr = 0; end
    else if (ms == 0 || ms == 5) begin
      if (blk) ms = 6; else if (go) begin ms = 1; tmr = 2; end
    end else if (ms == 1 || ms == 3) begin
      tmr = tmr - 1;
      if (tmr == 0) ms = ms + 1;
    end else if (ms == 2) begin
      if (stop) begin ms = 3; tmr = 2; end
    end else if (ms == 4) ms = 5;
    else if (ms == 6 && crc) begin
      if (go) begin ms = 1; tmr = 2; end else ms = 5;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!done) chk("R12 oe before falling edge", d2_oe, int'((pms >= 2 && pms <= 4) && dp));
      #13;
      if (!done) begin
        chk("R11 state", st, ms);
        chk("R3 d2_oe", d2_oe, int'((ms >= 2 && ms <= 4) && dp));
        chk("R4 d2 value", d2, int'(ms == 4));
        chk("R8 irq", irq, int'(ms >= 1 && ms <= 3 && !d1));
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run(3);
    chk("R11 reset state", st, 0);
    chk("R11 reset oe", d2_oe, 0);
    rst_n = 1;
    // R9: sdio mode off
    dp = 1; dir = 1; start = 1; sd = 0;
    run(4); #16;
    chk("R9 stays idle", st, 0);
    chk("R9 d2 released", d2_oe, 0);
    // R1: method and direction gating
    sd = 1; meth = 1;
    run(4); #16; chk("R1 method=1 idle", st, 0);
    meth = 0; dir = 0; d1 = 0;
    run(4); #16;
    chk("R1 dir=0 idle", st, 0);
    chk("R8 no irq in idle", irq, 0);
    d1 = 1;
    // R2/R3 entry
    dir = 1;
    run(1); #16; chk("R2 direct entry", st, 1);
    run(1); #16; chk("R3 released 2nd delay cycle", d2_oe, 0);
    run(1); #16; chk("R3 hold state", st, 2); chk("R3 d2 low", d2_oe & ~d2, 1);
    d1 = 0; #1; chk("R8 irq on D1 low", irq, 1); d1 = 1;
    // R4/R5 stop
    stop = 1;
    run(1); #16; chk("R4 stop delay 1", st, 3); chk("R4 still low", d2, 0);
    run(1); #16; chk("R4 stop delay 2", st, 3);
    run(1); #16; chk("R4 pulse", st, 4); chk("R4 d2 high", d2 & d2_oe, 1);
    run(1); #16; chk("R5 wait data", st, 5); chk("R5 released", d2_oe, 0);
    // R7
    run(3); #16; chk("R7 stop still set", st, 5);
    stop = 0;
    run(1); #16; chk("R7 restart after clear", st, 1);
    run(2); stop = 1; run(4); #16; chk("R5 back to wait", st, 5);
    start = 0; stop = 0;
    // R6 postpone
    blk = 1;
    run(1); #16; chk("R6 receiving", st, 6);
    start = 1;
    run(3); #16; chk("R6 no mid-block entry", st, 6); chk("R6 d2 released", d2_oe, 0);
    blk = 0; crc = 1;
    run(1); #16; chk("R6 entry after crc", st, 1);
    crc = 0;
    run(2); #16; chk("R3 hold again", st, 2);
    // R10
    dp = 0; #1;
    chk("R10 oe drops at once", d2_oe, 0);
    run(1); #16; chk("R10 idle", st, 0);
    run(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule